// File: doc/BRIEF.md
# Issue-Stage Latency Scoreboard

This block sits at the issue point of a single-issue, in-order pipeline. Each cycle it looks at one candidate instruction: an operation class, an optional destination register and up to two source registers. It raises a stall while the candidate touches a register whose result is still on its way. Operations carry no data. Each one that writes a register becomes a timed token. The token holds its destination reserved for the latency of its class, then competes for the single register-file write port and releases the reservation when it wins.

Every token lives in one of a small, parameterised set of tracking slots. Each slot is a three-state machine. In `SLOT_FREE` it is empty. Transition *launch* moves it to `SLOT_FLIGHT`, where a countdown runs. Transition *launch-short*, for latency 1, takes it straight to `SLOT_DUE`. Transition *expire* takes it from `SLOT_FLIGHT` to `SLOT_DUE` when the countdown ends. Transition *retire* takes it from `SLOT_DUE` back to `SLOT_FREE` when the write port is granted. Transition *clear*, the synchronous reset, returns every slot to `SLOT_FREE`. A slot that is due but loses arbitration stays in `SLOT_DUE` and keeps its register reserved. The write port goes to the oldest due token.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: After reset no register is reserved: a valid candidate with any sources and destination sees stall low, and `wb_valid` is low.
- R2: Class codes on `iss_class` are: 0 integer and 7 misc (latency 1), 1 load (3), 2 store, 3 single-precision float add (5), 4 mixed-precision float add (6), 5 float multiply (6), 6 branch. An uncontended writing operation issued in cycle c shows `wb_valid` with its register in cycle c+latency.
- R3: A valid candidate with an enabled source that matches a reserved register stalls. It can issue in the cycle after that register's write-back, so a dependent of an uncontended producer stalls for exactly the producer's latency.
- R4: A writing candidate whose destination is already reserved stalls in the same way until that register is written back.
- R5: Store and branch classes never reserve a register and never produce a write-back, even with `iss_has_dst` high. They stall only on their sources, so they can issue on consecutive cycles.
- R6: At most one write-back occurs per cycle. When several tokens are due together, the one issued earliest goes first. The others wait and keep their registers reserved until their own write-back.
- R7: When every tracking slot is occupied, a writing candidate stalls; a non-writing candidate does not stall for that reason.
- R8: Stall is low whenever `iss_valid` is low, and a stalled candidate reserves nothing.
- R9: Synchronous reset in the middle of operation drops every reservation and every pending write-back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Candidate instruction present |
| iss_class | input | 3 | Operation class code (see R2) |
| iss_has_dst | input | 1 | Candidate names a destination |
| iss_dst | input | RW | Destination register index |
| iss_src_a_en | input | 1 | First source in use |
| iss_src_a | input | RW | First source register index |
| iss_src_b_en | input | 1 | Second source in use |
| iss_src_b | input | RW | Second source register index |
| iss_stall | output | 1 | Candidate must be held this cycle |
| wb_valid | output | 1 | A write-back happens this cycle |
| wb_reg | output | RW | Register written back this cycle |

## Verification
The bench builds three-way collisions on the write port, where a multiply, an add and an integer operation all fall due in the same cycle. It checks that they leave in issue order and that a reader of the last one keeps stalling while it waits. A design that picked by slot index or let the loser release early would emit the wrong register or let the reader through. It fills every slot to show that writers stall and stores do not. It resets with a long operation in flight to catch a leftover write-back. A long run of random hazard-heavy instructions on eight registers, compared cycle by cycle with a reference model, catches off-by-one countdowns and missed source or destination comparisons.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [2:0] {
        OPC_INT      = 3'd0,
        OPC_LOAD     = 3'd1,
        OPC_STORE    = 3'd2,
        OPC_FADD_SP  = 3'd3,
        OPC_FADD_MIX = 3'd4,
        OPC_FMUL     = 3'd5,
        OPC_BRANCH   = 3'd6,
        OPC_MISC     = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_FLIGHT = 2'd1,
        SLOT_DUE    = 2'd2
    } slot_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode
    import sb_pkg::*;
#(
    parameter int unsigned LAT_INT      = 1,
    parameter int unsigned LAT_LOAD     = 3,
    parameter int unsigned LAT_FADD_SP  = 5,
    parameter int unsigned LAT_FADD_MIX = 6,
    parameter int unsigned LAT_FMUL     = 6,
    parameter int unsigned CNT_W        = 3
) (
    input  logic [2:0]       opc,
    output logic             writes,
    output logic [CNT_W-1:0] lat
);

    always_comb begin
        writes = 1'b1;
        lat    = CNT_W'(LAT_INT);
        unique case (opc_e'(opc))
            OPC_INT, OPC_MISC: lat = CNT_W'(LAT_INT);
            OPC_LOAD:          lat = CNT_W'(LAT_LOAD);
            OPC_FADD_SP:       lat = CNT_W'(LAT_FADD_SP);
            OPC_FADD_MIX:      lat = CNT_W'(LAT_FADD_MIX);
            OPC_FMUL:          lat = CNT_W'(LAT_FMUL);
            OPC_STORE, OPC_BRANCH: begin
                writes = 1'b0;
                lat    = CNT_W'(LAT_INT);
            end
        endcase
    end

endmodule

// File: rtl/sb_slot.sv
module sb_slot
    import sb_pkg::*;
#(
    parameter int unsigned RW    = 5,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [RW-1:0]    alloc_dst,
    input  logic [CNT_W-1:0] alloc_lat,
    input  logic             grant,
    output logic             busy,
    output logic             due,
    output logic [RW-1:0]    dst,
    output logic [AGE_W-1:0] age
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [RW-1:0]    dst_q, dst_d;
    logic [AGE_W-1:0] age_q, age_d;
    logic [AGE_W-1:0] age_inc;

    assign age_inc = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_FREE;
            cnt_q   <= '0;
            dst_q   <= '0;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dst_q   <= dst_d;
            age_q   <= age_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dst_d   = dst_q;
        age_d   = age_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc) begin
                    dst_d = alloc_dst;
                    age_d = '0;
                    if (alloc_lat <= CNT_W'(1)) begin
                        state_d = SLOT_DUE;            // launch-short
                        cnt_d   = '0;
                    end else begin
                        state_d = SLOT_FLIGHT;         // launch
                        cnt_d   = alloc_lat - CNT_W'(1);
                    end
                end
            end
            SLOT_FLIGHT: begin
                age_d = age_inc;
                cnt_d = cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    state_d = SLOT_DUE;                // expire
                end
            end
            SLOT_DUE: begin
                age_d = age_inc;
                if (grant) begin
                    state_d = SLOT_FREE;               // retire
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != SLOT_FREE);
        due  = (state_q == SLOT_DUE);
        dst  = dst_q;
        age  = age_q;
    end

    assert_flight_count_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_FLIGHT) |-> (cnt_q != '0));

    assert_due_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_DUE && !grant) |=> (state_q == SLOT_DUE && $stable(dst_q)));

    assert_alloc_free_R7: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (state_q == SLOT_FREE));

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned AGE_W = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SLOTS-1:0]            due,
    input  logic [SLOTS-1:0][AGE_W-1:0] age,
    output logic [SLOTS-1:0]            grant,
    output logic                        any
);

    localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [IW-1:0]    best_idx;
    logic [AGE_W-1:0] best_age;
    logic             found;

    always_comb begin
        best_idx = '0;
        best_age = '0;
        found    = 1'b0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (due[i] && (!found || age[i] > best_age)) begin
                best_idx = IW'(i);
                best_age = age[i];
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < int'(SLOTS); i++) begin
            grant[i] = found && (best_idx == IW'(i));
        end
        any = found;
    end

    assert_one_port_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_due_R6: assert property (@(posedge clk) disable iff (rst)
        (grant & ~due) == '0);

    assert_no_idle_port_R6: assert property (@(posedge clk) disable iff (rst)
        (due != '0) |-> any);

endmodule

// File: rtl/sb_issue_scoreboard.sv
module sb_issue_scoreboard
    import sb_pkg::*;
#(
    parameter int unsigned REG_COUNT    = 32,
    parameter int unsigned SLOTS        = 8,
    parameter int unsigned LAT_INT      = 1,
    parameter int unsigned LAT_LOAD     = 3,
    parameter int unsigned LAT_FADD_SP  = 5,
    parameter int unsigned LAT_FADD_MIX = 6,
    parameter int unsigned LAT_FMUL     = 6,
    localparam int unsigned RW          = $clog2(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic [2:0]    iss_class,
    input  logic          iss_has_dst,
    input  logic [RW-1:0] iss_dst,
    input  logic          iss_src_a_en,
    input  logic [RW-1:0] iss_src_a,
    input  logic          iss_src_b_en,
    input  logic [RW-1:0] iss_src_b,
    output logic          iss_stall,
    output logic          wb_valid,
    output logic [RW-1:0] wb_reg
);

    localparam int unsigned MAX_LAT = max2(max2(LAT_INT, LAT_LOAD),
                                           max2(max2(LAT_FADD_SP, LAT_FADD_MIX), LAT_FMUL));
    localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);
    localparam int unsigned AGE_W   = $clog2(MAX_LAT + SLOTS + 2) + 1;

    logic                        dec_writes;
    logic [CNT_W-1:0]            dec_lat;
    logic [SLOTS-1:0]            slot_busy;
    logic [SLOTS-1:0]            slot_due;
    logic [SLOTS-1:0]            slot_grant;
    logic [SLOTS-1:0]            alloc_vec;
    logic [SLOTS-1:0][RW-1:0]    slot_dst;
    logic [SLOTS-1:0][AGE_W-1:0] slot_age;
    logic [REG_COUNT-1:0]        pend;
    logic                        dst_writes;
    logic                        raw_hit;
    logic                        waw_hit;
    logic                        full_hit;
    logic                        accept;
    logic                        port_busy;

    sb_class_decode #(
        .LAT_INT      (LAT_INT),
        .LAT_LOAD     (LAT_LOAD),
        .LAT_FADD_SP  (LAT_FADD_SP),
        .LAT_FADD_MIX (LAT_FADD_MIX),
        .LAT_FMUL     (LAT_FMUL),
        .CNT_W        (CNT_W)
    ) i_decode (
        .opc    (iss_class),
        .writes (dec_writes),
        .lat    (dec_lat)
    );

    // reservation map from occupied slots
    always_comb begin
        pend = '0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (slot_busy[i]) begin
                pend[slot_dst[i]] = 1'b1;
            end
        end
    end

    // hazard detection
    always_comb begin
        dst_writes = iss_has_dst && dec_writes;
        raw_hit    = (iss_src_a_en && pend[iss_src_a]) || (iss_src_b_en && pend[iss_src_b]);
        waw_hit    = dst_writes && pend[iss_dst];
        full_hit   = dst_writes && (&slot_busy);
        iss_stall  = iss_valid && (raw_hit || waw_hit || full_hit);
        accept     = iss_valid && !iss_stall && dst_writes;
    end

    // lowest free slot takes the new token
    always_comb begin
        logic taken;
        taken     = 1'b0;
        alloc_vec = '0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (!slot_busy[i] && !taken) begin
                alloc_vec[i] = accept;
                taken        = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < int'(SLOTS); g++) begin : g_slot
        sb_slot #(
            .RW    (RW),
            .CNT_W (CNT_W),
            .AGE_W (AGE_W)
        ) i_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_vec[g]),
            .alloc_dst (iss_dst),
            .alloc_lat (dec_lat),
            .grant     (slot_grant[g]),
            .busy      (slot_busy[g]),
            .due       (slot_due[g]),
            .dst       (slot_dst[g]),
            .age       (slot_age[g])
        );
    end

    sb_wb_arbiter #(
        .SLOTS (SLOTS),
        .AGE_W (AGE_W)
    ) i_arb (
        .clk   (clk),
        .rst   (rst),
        .due   (slot_due),
        .age   (slot_age),
        .grant (slot_grant),
        .any   (port_busy)
    );

    always_comb begin
        wb_valid = port_busy;
        wb_reg   = '0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (slot_grant[i]) begin
                wb_reg = wb_reg | slot_dst[i];
            end
        end
    end

    assert_reserve_after_issue_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_stall && iss_has_dst && dec_writes) |=> pend[$past(iss_dst)]);

    assert_stall_no_alloc_R8: assert property (@(posedge clk) disable iff (rst)
        iss_stall |-> (alloc_vec == '0));

    assert_idle_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> !iss_stall);

    assert_nonwriter_no_alloc_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_class == OPC_STORE || iss_class == OPC_BRANCH) |-> (alloc_vec == '0));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (pend == '0 && !wb_valid));

endmodule

// File: tb/test_sb_issue_scoreboard.sv
module test_sb_issue_scoreboard;

    localparam int NREG  = 32;
    localparam int NSLOT = 4;

    typedef struct {
        bit v;
        int cls;
        bit hd;
        int d;
        bit av;
        int a;
        bit bv;
        int b;
    } ins_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_class = '0;
    logic       iss_has_dst = 1'b0;
    logic [4:0] iss_dst = '0;
    logic       iss_src_a_en = 1'b0;
    logic [4:0] iss_src_a = '0;
    logic       iss_src_b_en = 1'b0;
    logic [4:0] iss_src_b = '0;
    logic       iss_stall;
    logic       wb_valid;
    logic [4:0] wb_reg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    bit m_v   [NSLOT];
    int m_dst [NSLOT];
    int m_rem [NSLOT];
    int m_seq [NSLOT];
    int seqc = 0;

    always #5 clk = ~clk;

    sb_issue_scoreboard #(.REG_COUNT(NREG), .SLOTS(NSLOT)) i_sb_issue_scoreboard (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
        .iss_src_a_en(iss_src_a_en), .iss_src_a(iss_src_a),
        .iss_src_b_en(iss_src_b_en), .iss_src_b(iss_src_b),
        .iss_stall(iss_stall), .wb_valid(wb_valid), .wb_reg(wb_reg)
    );

    function automatic int exp_lat(input int cls);
        case (cls)
            1: return 3;
            3: return 5;
            4: return 6;
            5: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic bit exp_writes(input int cls);
        return !(cls == 2 || cls == 6);
    endfunction

    function automatic ins_t mk(input bit v, input int cls, input bit hd, input int d,
                                input bit av, input int a, input bit bv, input int b);
        ins_t x;
        x.v = v; x.cls = cls; x.hd = hd; x.d = d; x.av = av; x.a = a; x.bv = bv; x.b = b;
        return x;
    endfunction

    function automatic ins_t nop();
        return mk(0, 0, 0, 0, 0, 0, 0, 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NSLOT; i++) m_v[i] = 0;
    endtask

    task automatic step(input ins_t x, input bit r, input string tag,
                        output bit st, output bit wv, output int wr);
        bit pend [NREG];
        bit full;
        bit e_stall;
        bit wrt;
        int win;
        int freei;
        @(negedge clk);
        rst          = r;
        iss_valid    = x.v;
        iss_class    = 3'(x.cls);
        iss_has_dst  = x.hd;
        iss_dst      = 5'(x.d);
        iss_src_a_en = x.av;
        iss_src_a    = 5'(x.a);
        iss_src_b_en = x.bv;
        iss_src_b    = 5'(x.b);
        #1;
        for (int k = 0; k < NREG; k++) pend[k] = 0;
        full  = 1;
        win   = -1;
        freei = -1;
        for (int i = 0; i < NSLOT; i++) begin
            if (m_v[i]) begin
                pend[m_dst[i]] = 1;
                if (m_rem[i] == 0 && (win < 0 || m_seq[i] < m_seq[win])) win = i;
            end else begin
                full = 0;
                if (freei < 0) freei = i;
            end
        end
        wrt     = x.hd && exp_writes(x.cls);
        e_stall = x.v && ((x.av && pend[x.a]) || (x.bv && pend[x.b]) ||
                          (wrt && (pend[x.d] || full)));
        chk(iss_stall === e_stall, tag, "stall", int'(iss_stall), int'(e_stall));
        chk(wb_valid === (win >= 0) && (win < 0 || wb_reg === 5'(m_dst[win])), tag, "writeback reg",
            wb_valid ? int'(wb_reg) : -1, (win >= 0) ? m_dst[win] : -1);
        st = iss_stall;
        wv = wb_valid;
        wr = int'(wb_reg);
        if (r) begin
            model_clear();
        end else begin
            if (win >= 0) m_v[win] = 0;
            for (int i = 0; i < NSLOT; i++) if (m_v[i] && m_rem[i] > 0) m_rem[i]--;
            if (x.v && !e_stall && wrt) begin
                m_v[freei]   = 1;
                m_dst[freei] = x.d;
                m_rem[freei] = exp_lat(x.cls) - 1;
                m_seq[freei] = seqc++;
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        bit s, w; int rr;
        for (int i = 0; i < n; i++) step(nop(), 0, tag, s, w, rr);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit s, w;
        int rr, cnt, seen;
        int cls_list [5] = '{0, 1, 3, 4, 5};
        int dummy;
        dummy = $urandom(32'd20240611);
        model_clear();
        for (int i = 0; i < 3; i++) step(nop(), 1, "R9", s, w, rr);

        // R1: nothing reserved after reset
        step(mk(1, 0, 1, 2, 1, 0, 1, 1), 0, "R1", s, w, rr);
        chk(s == 0 && w == 0, "R1", "reset stall/wb", int'(s) + 2 * int'(w), 0);
        idle(3, "R1");

        // R2: latency per class
        foreach (cls_list[j]) begin
            step(mk(1, cls_list[j], 1, 10, 0, 0, 0, 0), 0, "R2", s, w, rr);
            seen = 0;
            for (int k = 1; k <= 10; k++) begin
                step(nop(), 0, "R2", s, w, rr);
                if (w && seen == 0) begin
                    seen = k;
                    chk(rr == 10, "R2", "latency reg", rr, 10);
                end
            end
            chk(seen == exp_lat(cls_list[j]), "R2", "latency", seen, exp_lat(cls_list[j]));
        end

        // R3: read-after-write stall length
        step(mk(1, 1, 1, 5, 0, 0, 0, 0), 0, "R3", s, w, rr);
        cnt = 0;
        do begin
            step(mk(1, 0, 1, 6, 0, 0, 1, 5), 0, "R3", s, w, rr);
            if (s) cnt++;
        end while (s && cnt < 20);
        chk(cnt == 3, "R3", "raw stall cycles", cnt, 3);
        idle(3, "R3");

        // R4: write-after-write stall length
        step(mk(1, 3, 1, 7, 0, 0, 0, 0), 0, "R4", s, w, rr);
        cnt = 0;
        do begin
            step(mk(1, 0, 1, 7, 0, 0, 0, 0), 0, "R4", s, w, rr);
            if (s) cnt++;
        end while (s && cnt < 20);
        chk(cnt == 5, "R4", "waw stall cycles", cnt, 5);
        idle(3, "R4");

        // R5: store and branch reserve nothing
        step(mk(1, 2, 1, 9, 0, 0, 0, 0), 0, "R5", s, w, rr);
        chk(s == 0, "R5", "store issue", int'(s), 0);
        step(mk(1, 6, 1, 11, 0, 0, 0, 0), 0, "R5", s, w, rr);
        chk(s == 0, "R5", "branch back-to-back", int'(s), 0);
        step(mk(1, 2, 1, 9, 1, 9, 1, 11), 0, "R5", s, w, rr);
        chk(s == 0, "R5", "reader of store/branch dst", int'(s), 0);
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            step(nop(), 0, "R5", s, w, rr);
            if (w) seen++;
        end
        chk(seen == 0, "R5", "no writeback", seen, 0);

        // R6: three tokens due together leave oldest first
        step(mk(1, 5, 1, 1, 0, 0, 0, 0), 0, "R6", s, w, rr);
        step(mk(1, 3, 1, 2, 0, 0, 0, 0), 0, "R6", s, w, rr);
        idle(3, "R6");
        step(mk(1, 0, 1, 3, 0, 0, 0, 0), 0, "R6", s, w, rr);
        step(nop(), 0, "R6", s, w, rr);
        chk(w && rr == 1, "R6", "first writeback", w ? rr : -1, 1);
        step(mk(1, 0, 1, 4, 1, 3, 0, 0), 0, "R6", s, w, rr);
        chk(w && rr == 2, "R6", "second writeback", w ? rr : -1, 2);
        chk(s == 1, "R6", "deferred reg still reserved", int'(s), 1);
        step(nop(), 0, "R6", s, w, rr);
        chk(w && rr == 3, "R6", "third writeback", w ? rr : -1, 3);
        idle(3, "R6");

        // R7: all slots busy
        for (int k = 1; k <= 4; k++) step(mk(1, 5, 1, k, 0, 0, 0, 0), 0, "R7", s, w, rr);
        step(mk(1, 0, 1, 5, 0, 0, 0, 0), 0, "R7", s, w, rr);
        chk(s == 1, "R7", "writer stalls when full", int'(s), 1);
        step(mk(1, 2, 0, 0, 1, 6, 0, 0), 0, "R7", s, w, rr);
        chk(s == 0, "R7", "store passes when full", int'(s), 0);
        idle(10, "R7");

        // R8: invalid candidate never stalls
        step(mk(1, 1, 1, 8, 0, 0, 0, 0), 0, "R8", s, w, rr);
        step(mk(0, 0, 1, 8, 1, 8, 1, 8), 0, "R8", s, w, rr);
        chk(s == 0, "R8", "idle stall", int'(s), 0);
        idle(4, "R8");

        // R9: reset mid-flight
        step(mk(1, 5, 1, 1, 0, 0, 0, 0), 0, "R9", s, w, rr);
        step(nop(), 1, "R9", s, w, rr);
        step(mk(1, 0, 1, 2, 1, 1, 0, 0), 0, "R9", s, w, rr);
        chk(s == 0, "R9", "reservation dropped", int'(s), 0);
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            step(nop(), 0, "R9", s, w, rr);
            if (w && rr == 1) seen++;
        end
        chk(seen == 0, "R9", "stale writeback", seen, 0);

        // random hazard-heavy traffic (R3 R4 R6 R7 against model)
        for (int k = 0; k < 4000; k++) begin
            ins_t x;
            x = mk(($urandom % 5) != 0, int'($urandom % 8), $urandom % 2, int'($urandom % 8),
                   $urandom % 2, int'($urandom % 8), $urandom % 2, int'($urandom % 8));
            step(x, 0, "R6", s, w, rr);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule